// File: doc/BRIEF.md
# Centre-Spread Triangular Modulation Profile Generator

This block runs on the reference clock of a clock synthesiser and produces a signed frequency-offset word. A fractional feedback divider or a digitally controlled oscillator adds that word to its nominal setting, which spreads the synthesised clock symmetrically around its nominal frequency. The offset follows a triangle. Each modulation period starts at zero, climbs to the programmed peak, falls through zero to the negative peak, and comes back to zero. Because of this shape the average frequency over a period equals the nominal one.

A two-bit range code selects the period length in reference cycles and whether the synthesised output runs at one or two times the reference. The peak magnitude comes from an amplitude input. The range code and the amplitude are both sampled only at period boundaries, so a period always completes with the settings it started with. An enable input forces the offset to zero without stopping the period timing. The forbidden range code parks the block in an error state until a legal code appears. A one-cycle strobe marks each period start, and a half-rate phase output toggles every cycle while the profile runs.

Top module: `ssc_profile_gen`

## Requirements
- R1: Range code decode: 2'b00 gives a period of 1166 cycles with `mult_2x` low; 2'b01 gives 1166 cycles with `mult_2x` high; 2'b10 gives 2332 cycles with `mult_2x` low. `mult_2x` is low whenever the profile is not running.
- R2: `period_start` is high for exactly one cycle at each period start. The first pulse appears in the first cycle after reset is released, and later pulses are spaced by the period of the code latched at the previous pulse.
- R3: Code 2'b11, when sampled at a boundary, raises `range_err`, holds the offset at zero and suppresses `period_start`, `mult_2x` and `half_rate`. The code is then re-sampled every cycle. The first legal code starts a new period in the next cycle.
- R4: With index k (0 at the strobe), period P, H = P/2, Q = (H-1)/2 and step S = ceil(amp·4096/Q), the magnitude is floor(m·S/4096). Here m = j for j ≤ Q, m = H-1-j for j ≥ H-1-Q, and m = Q between those, where j = k mod H. The offset is +magnitude for k < H and -magnitude for k ≥ H.
- R5: The offset equals +amp at k = Q, -amp at k = H+Q and zero at k = 0 and k = H. Its magnitude never exceeds the latched amplitude.
- R6: Over any full period with modulation enabled, the offsets sum to zero.
- R7: While `mod_en` is low, the offset is zero in the same cycle. Period timing and `period_start` continue. When `mod_en` goes high again, the offset returns to the profile value for the current index.
- R8: Changes to the range code or the amplitude in the middle of a period have no effect until the next period start.
- R9: While running, `half_rate` equals bit 0 of k. It is low in the strobe cycle and toggles every cycle.
- R10: During reset, and until the first load, the offset is zero and `period_start`, `mult_2x`, `range_err` and `half_rate` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| range_sel | input | 2 | Range code (period length and multiplier) |
| spread_amp | input | AMP_W | Peak offset magnitude |
| mod_en | input | 1 | Modulation enable, zero offset when low |
| freq_offset | output | AMP_W+1 | Signed frequency-offset word |
| mult_2x | output | 1 | Output multiplier is 2X |
| range_err | output | 1 | Illegal range code is in force |
| period_start | output | 1 | One-cycle strobe at each period start |
| half_rate | output | 1 | Half-rate phase, toggles each running cycle |

## Verification
The assertions check, on every cycle, the properties that hold in any state: the zero offset under error or disable, the single-cycle strobe, the measured period length against the latched period, the bound on the offset magnitude, the half-rate toggling and the persistence of the error state. The exact value of the triangle at each index, the zero sum over a period, the effect of changes applied mid-period only at the next boundary, and the restart after a legal code follows the error state all depend on what was applied and when. Only the bench's scenarios and its reference model show these.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

  typedef enum logic [1:0] {
    RNG_SHORT_1X = 2'b00,
    RNG_SHORT_2X = 2'b01,
    RNG_LONG_1X  = 2'b10,
    RNG_ILLEGAL  = 2'b11
  } rng_code_e;

  // Ramp length in cycles from zero to peak, for a full period per.
  function automatic int unsigned ramp_len(input int unsigned per);
    return ((per >> 1) - 1) >> 1;
  endfunction

  // Fixed-point increment, rounded up so the ramp lands exactly on amp.
  function automatic int unsigned ramp_step(input int unsigned amp,
                                            input int unsigned frac,
                                            input int unsigned ramp);
    if (ramp == 0) return 0;
    return ((amp << frac) + ramp - 1) / ramp;
  endfunction

endpackage

// File: rtl/ssc_range_decode.sv
module ssc_range_decode #(
  parameter int unsigned PER_SHORT = 1166,
  parameter int unsigned PER_LONG  = 2332,
  parameter int unsigned CNT_W     = 12
) (
  input  logic [1:0]       code,
  output logic             legal,
  output logic [CNT_W-1:0] period,
  output logic             dbl
);
  import ssc_pkg::*;

  always_comb begin
    legal  = 1'b1;
    period = CNT_W'(PER_SHORT);
    dbl    = 1'b0;
    case (code)
      RNG_SHORT_1X: ;
      RNG_SHORT_2X: dbl = 1'b1;
      RNG_LONG_1X:  period = CNT_W'(PER_LONG);
      default:      legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/ssc_period_ctrl.sv
module ssc_period_ctrl #(
  parameter int unsigned PER_SHORT = 1166,
  parameter int unsigned PER_LONG  = 2332,
  parameter int unsigned AMP_W     = 8,
  parameter int unsigned FRAC_W    = 12,
  parameter int unsigned CNT_W     = 12,
  parameter int unsigned STEP_W    = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        range_sel,
  input  logic [AMP_W-1:0]  spread_amp,
  output logic              load,
  output logic              loaded_q,
  output logic              err_q,
  output logic              dbl_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [CNT_W-1:0]  per_q,
  output logic [STEP_W-1:0] step_q,
  output logic [AMP_W-1:0]  amp_q
);
  import ssc_pkg::*;

  logic             dec_legal;
  logic             dec_dbl;
  logic [CNT_W-1:0] dec_per;
  logic             last_cyc;

  ssc_range_decode #(
    .PER_SHORT(PER_SHORT),
    .PER_LONG (PER_LONG),
    .CNT_W    (CNT_W)
  ) u_dec (
    .code  (range_sel),
    .legal (dec_legal),
    .period(dec_per),
    .dbl   (dec_dbl)
  );

  // Named boundary events, also used by the bound checker.
  assign last_cyc = (cnt_q == (per_q - CNT_W'(1)));
  assign load     = !loaded_q || err_q || last_cyc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loaded_q <= 1'b0;
      err_q    <= 1'b0;
      dbl_q    <= 1'b0;
      cnt_q    <= '0;
      per_q    <= CNT_W'(PER_SHORT);
      step_q   <= '0;
      amp_q    <= '0;
    end else if (load) begin
      loaded_q <= 1'b1;
      cnt_q    <= '0;
      if (!dec_legal) begin
        err_q <= 1'b1;
      end else begin
        err_q  <= 1'b0;
        per_q  <= dec_per;
        dbl_q  <= dec_dbl;
        amp_q  <= spread_amp;
        step_q <= STEP_W'(ramp_step(32'(spread_amp), FRAC_W,
                                    ramp_len(32'(dec_per))));
      end
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/ssc_tri_accum.sv
module ssc_tri_accum #(
  parameter int unsigned AMP_W  = 8,
  parameter int unsigned FRAC_W = 12,
  parameter int unsigned CNT_W  = 12,
  localparam int unsigned ACC_W = AMP_W + FRAC_W + 1,
  localparam int unsigned OFS_W = AMP_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    restart,
  input  logic [CNT_W-1:0]        cnt,
  input  logic [CNT_W-1:0]        per,
  input  logic [ACC_W-1:0]        step,
  output logic signed [OFS_W-1:0] offset_raw
);
  logic [ACC_W-1:0] mag_q;
  logic [CNT_W-1:0] half_len;
  logic [CNT_W-1:0] ramp;
  logic [CNT_W-1:0] j_idx;
  logic             neg_half;
  logic [AMP_W-1:0] mag_int;

  assign half_len = per >> 1;
  assign ramp     = (half_len - CNT_W'(1)) >> 1;
  assign neg_half = (cnt >= half_len);
  assign j_idx    = neg_half ? (cnt - half_len) : cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mag_q <= '0;
    end else if (restart || (j_idx == half_len - CNT_W'(1))) begin
      mag_q <= '0;
    end else if (j_idx < ramp) begin
      mag_q <= mag_q + step;
    end else if (j_idx >= half_len - CNT_W'(1) - ramp) begin
      mag_q <= mag_q - step;
    end
  end

  assign mag_int    = mag_q[FRAC_W +: AMP_W];
  assign offset_raw = neg_half ? -$signed({1'b0, mag_int}) : $signed({1'b0, mag_int});
endmodule

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen #(
  parameter int unsigned PER_SHORT = 1166,
  parameter int unsigned PER_LONG  = 2332,
  parameter int unsigned AMP_W     = 8,
  parameter int unsigned FRAC_W    = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              range_sel,
  input  logic [AMP_W-1:0]        spread_amp,
  input  logic                    mod_en,
  output logic signed [AMP_W:0]   freq_offset,
  output logic                    mult_2x,
  output logic                    range_err,
  output logic                    period_start,
  output logic                    half_rate
);
  localparam int unsigned CNT_W  = $clog2(PER_LONG + 1);
  localparam int unsigned STEP_W = AMP_W + FRAC_W + 1;

  logic              load;
  logic              loaded_q;
  logic              err_q;
  logic              dbl_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  per_q;
  logic [STEP_W-1:0] step_q;
  logic [AMP_W-1:0]  amp_q;
  logic signed [AMP_W:0] raw_off;
  logic              running;

  ssc_period_ctrl #(
    .PER_SHORT(PER_SHORT),
    .PER_LONG (PER_LONG),
    .AMP_W    (AMP_W),
    .FRAC_W   (FRAC_W),
    .CNT_W    (CNT_W),
    .STEP_W   (STEP_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .range_sel (range_sel),
    .spread_amp(spread_amp),
    .load      (load),
    .loaded_q  (loaded_q),
    .err_q     (err_q),
    .dbl_q     (dbl_q),
    .cnt_q     (cnt_q),
    .per_q     (per_q),
    .step_q    (step_q),
    .amp_q     (amp_q)
  );

  ssc_tri_accum #(
    .AMP_W (AMP_W),
    .FRAC_W(FRAC_W),
    .CNT_W (CNT_W)
  ) u_tri (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (load),
    .cnt       (cnt_q),
    .per       (per_q),
    .step      (step_q),
    .offset_raw(raw_off)
  );

  assign running      = loaded_q && !err_q;
  assign freq_offset  = (running && mod_en) ? raw_off : '0;
  assign period_start = running && (cnt_q == '0);
  assign mult_2x      = running && dbl_q;
  assign range_err    = err_q;
  assign half_rate    = running && cnt_q[0];
endmodule

// File: rtl/ssc_profile_chk.sv
module ssc_profile_chk #(
  parameter int unsigned AMP_W     = 8,
  parameter int unsigned CNT_W     = 12,
  parameter int unsigned PER_SHORT = 1166
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [1:0]            range_sel,
  input logic                  mod_en,
  input logic signed [AMP_W:0] freq_offset,
  input logic                  mult_2x,
  input logic                  range_err,
  input logic                  period_start,
  input logic                  half_rate,
  input logic                  running,
  input logic [CNT_W-1:0]      per_q,
  input logic [AMP_W-1:0]      amp_q
);
  logic [CNT_W-1:0] gap_q;
  logic [CNT_W-1:0] last_per_q;
  logic             seen_q;
  logic [AMP_W:0]   mag_abs;

  assign mag_abs = (freq_offset < 0) ? AMP_W'(0) - AMP_W'(0) + $unsigned(-freq_offset)
                                     : $unsigned(freq_offset);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q      <= '0;
      last_per_q <= '0;
      seen_q     <= 1'b0;
    end else begin
      if (period_start) begin
        gap_q      <= '0;
        last_per_q <= per_q;
        seen_q     <= 1'b1;
      end else begin
        if (gap_q != '1) gap_q <= gap_q + CNT_W'(1);
        if (range_err) seen_q <= 1'b0;
      end
    end
  end

  assert_err_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    range_err |-> (freq_offset == 0 && !period_start && !mult_2x && !half_rate));

  assert_err_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (range_err && range_sel == 2'b11) |=> range_err);

  assert_disable_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |-> (freq_offset == 0));

  assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |=> !period_start);

  assert_period_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (period_start && seen_q) |-> ((gap_q + CNT_W'(1)) == last_per_q));

  assert_peak_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (mag_abs <= {1'b0, amp_q}));

  assert_zero_at_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |-> (freq_offset == 0));

  assert_mult_short_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mult_2x |-> (per_q == CNT_W'(PER_SHORT)));

  assert_half_toggle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !period_start) |-> (half_rate != $past(half_rate)));

  assert_half_low_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |-> !half_rate);
endmodule

bind ssc_profile_gen ssc_profile_chk #(
  .AMP_W    (AMP_W),
  .CNT_W    (CNT_W),
  .PER_SHORT(PER_SHORT)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .range_sel   (range_sel),
  .mod_en      (mod_en),
  .freq_offset (freq_offset),
  .mult_2x     (mult_2x),
  .range_err   (range_err),
  .period_start(period_start),
  .half_rate   (half_rate),
  .running     (running),
  .per_q       (per_q),
  .amp_q       (amp_q)
);

// File: tb/ssc_profile_gen_test.sv
`timescale 1ns/1ps
module ssc_profile_gen_test;
  localparam int FRAC = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        range_sel = 2'b00;
  logic [7:0]        spread_amp = 8'd0;
  logic              mod_en = 1'b1;
  logic signed [8:0] freq_offset;
  logic              mult_2x, range_err, period_start, half_rate;

  ssc_profile_gen uut (
    .clk(clk), .rst_n(rst_n), .range_sel(range_sel), .spread_amp(spread_amp),
    .mod_en(mod_en), .freq_offset(freq_offset), .mult_2x(mult_2x),
    .range_err(range_err), .period_start(period_start), .half_rate(half_rate)
  );

  always #2.5 clk = ~clk;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  bit last_ps;

  function automatic int per_of(int code);
    return (code == 2) ? 2332 : 1166;
  endfunction

  // Closed-form triangle from R4, written by index rather than by accumulation.
  function automatic int exp_off(int k, int code, int amp);
    int p, h, q, s, j, m, mag;
    p = per_of(code); h = p / 2; q = (h - 1) / 2;
    s = (amp * (1 << FRAC) + q - 1) / q;
    j = (k < h) ? k : k - h;
    if (j <= q) m = j;
    else if (j >= h - 1 - q) m = h - 1 - j;
    else m = q;
    mag = (m * s) / (1 << FRAC);
    return (k < h) ? mag : -mag;
  endfunction

  // Reference model of sequencing (R1, R2, R3, R8)
  bit m_loaded, m_err;
  int m_k, m_code, m_amp;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_loaded <= 0; m_err <= 0; m_k <= 0;
    end else if (!m_loaded || m_err || m_k == per_of(m_code) - 1) begin
      m_loaded <= 1; m_k <= 0;
      if (range_sel == 2'b11) m_err <= 1;
      else begin
        m_err <= 0; m_code <= int'(range_sel); m_amp <= int'(spread_amp);
      end
    end else m_k <= m_k + 1;
  end

  task automatic chk(string req, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  int  gap = 0, sum = 0, prev_code = 0;
  bit  have = 0, sum_ok = 0;

  task automatic step1();
    bit run; int e; string rq, ct; int h, q;
    @(negedge clk);
    run = m_loaded && !m_err;
    e   = (run && mod_en) ? exp_off(m_k, m_code, m_amp) : 0;
    rq  = !m_loaded ? "R10" : (m_err ? "R3" : (!mod_en ? "R7" : "R4"));
    ct  = !m_loaded ? "R10" : (m_err ? "R3" : "R2");
    chk(rq, "offset", int'(freq_offset), e);
    chk(ct, "period_start", int'(period_start), int'(run && m_k == 0));
    chk(!m_loaded ? "R10" : "R1", "mult_2x", int'(mult_2x), int'(run && m_code == 1));
    chk(!m_loaded ? "R10" : "R3", "range_err", int'(range_err), int'(m_err));
    chk(!m_loaded ? "R10" : "R9", "half_rate", int'(half_rate), int'(run && (m_k % 2 == 1)));
    if (run && mod_en) begin
      h = per_of(m_code) / 2; q = (h - 1) / 2;
      if (m_k == q)     chk("R5", "positive peak", int'(freq_offset), m_amp);
      if (m_k == h + q) chk("R5", "negative peak", int'(freq_offset), -m_amp);
      if (m_k == h)     chk("R5", "mid-period zero", int'(freq_offset), 0);
    end
    if (range_err) have = 0;
    if (period_start) begin
      if (have) chk("R2", "period length", gap, per_of(prev_code));
      if (have && sum_ok) chk("R6", "offset sum over period", sum, 0);
      have = 1; sum = 0; sum_ok = 1; gap = 0; prev_code = m_code;
    end
    gap++;
    sum += int'(freq_offset);
    if (!mod_en) sum_ok = 0;
    last_ps = period_start;
  endtask

  task automatic run_n(int n);
    for (int i = 0; i < n; i++) step1();
  endtask

  task automatic wait_start();
    do step1(); while (!last_ps);
  endtask

  initial begin
    int cnt_ps, r;
    void'($urandom(32'd7741));
    // R10: reset state
    rst_n = 0; range_sel = 2'b10; spread_amp = 8'd77;
    run_n(4);
    chk("R10", "offset in reset", int'(freq_offset), 0);
    rst_n = 1;
    step1();
    chk("R2", "first strobe after reset", int'(period_start), 1);

    // R1/R4: short range 1X, then 2X
    range_sel = 2'b00; spread_amp = 8'd200;
    wait_start(); run_n(2332);
    range_sel = 2'b01; spread_amp = 8'd255;
    wait_start();
    chk("R1", "2X flag", int'(mult_2x), 1);
    run_n(2332);

    // R8: mid-period change applies only at the next boundary
    range_sel = 2'b00; spread_amp = 8'd60;
    wait_start(); run_n(100);
    range_sel = 2'b10; spread_amp = 8'd200;
    run_n(191);
    chk("R8", "old amplitude kept at quarter", int'(freq_offset), 60);
    wait_start(); run_n(582);
    chk("R8", "new amplitude after boundary", int'(freq_offset), 200);
    wait_start();

    // amplitude zero corner
    range_sel = 2'b00; spread_amp = 8'd0;
    wait_start(); run_n(1300);

    // R7: disable across a boundary
    spread_amp = 8'd123; wait_start(); run_n(200);
    mod_en = 0; cnt_ps = 0;
    for (int i = 0; i < 1500; i++) begin step1(); if (last_ps) cnt_ps++; end
    chk("R7", "strobes continue while disabled", int'(cnt_ps >= 1), 1);
    mod_en = 1; run_n(20);

    // R3: illegal code, hold, recovery
    range_sel = 2'b11;
    for (int i = 0; i < 2400 && !range_err; i++) step1();
    chk("R3", "error raised", int'(range_err), 1);
    cnt_ps = 0;
    for (int i = 0; i < 40; i++) begin step1(); if (last_ps) cnt_ps++; end
    chk("R3", "no strobe in error", cnt_ps, 0);
    range_sel = 2'b01; spread_amp = 8'd90;
    step1();
    chk("R3", "restart strobe", int'(period_start), 1);
    chk("R3", "error cleared", int'(range_err), 0);
    run_n(1200);

    // constrained random
    for (int it = 0; it < 25; it++) begin
      r = $urandom_range(0, 9);
      range_sel  = (r == 9) ? 2'b11 : 2'(r % 3);
      spread_amp = 8'($urandom_range(0, 255));
      mod_en     = ($urandom_range(0, 9) < 8);
      run_n($urandom_range(200, 2500));
    end
    range_sel = 2'b00; mod_en = 1; run_n(2400);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL R2 watchdog: actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule